// File: doc/BRIEF.md
# SPI Pin-Control and Flash-Window Controller

This peripheral is an SPI master with two selectable personalities. With the mode bit set, software owns the serial pins outright. Each write to the I/O control register sets MOSI, SCLK and three active-low chip selects. Each rising step of the SCLK bit captures one MISO bit into a shift register that software reads back later. With the mode bit cleared, the peripheral exposes a read-only flash window. A bus read inside that window turns into a complete serial fast-read on chip select 0, generated in hardware at a programmable clock rate. The bus is held until the 32-bit result is ready.

The bus side is a plain 32-bit request/ready port. The `bus_win` input separates register accesses from window accesses. Register accesses use byte offsets 0x0 (function select), 0x4 (control), 0x8 (I/O control) and 0xC (read-data shift). Window accesses carry a 24-bit byte address, which is sent verbatim to the flash. Only SPI mode 0 is produced: SCLK idles low, and MISO is taken at SCLK rising edges.

Top module: `spi_winctl`

## Requirements
- R1: After reset, function select reads 0, control reads 0x00000043, I/O control reads 0x00070000 and read-data shift reads 0. All chip-select pins are high, and SCLK and MOSI are low.
- R2: A register read or write is answered with a one-cycle `bus_ready` pulse in the cycle after the request is first seen. Function select (bit 0), control and I/O control read back what was written.
- R3: With function select bit 0 set, the pins follow I/O control one clock after the write is accepted: bit 0 drives MOSI, bit 8 drives SCLK and bits 16, 17 and 18 drive chip selects 0, 1 and 2.
- R4: The read-data shift register shifts left and loads MISO into bit 0 only on an I/O control write that takes bit 8 from 0 to 1 while function select bit 0 is set. Other I/O control writes, writes made in window mode and writes to offset 0xC leave it unchanged.
- R5: A window read in window mode drives 72 SCLK rising edges with chip select 0 low and chip selects 1 and 2 high. MOSI carries 0x0B, then the 24-bit address, then eight zero bits, each MSB first.
- R6: The 32 bits sampled after the first 40 edges form the result. The first received byte is returned in `bus_rdata[7:0]` and the fourth in [31:24], each byte received MSB first. `bus_ready` stays low until the frame ends.
- R7: During a window read, each SCLK high and low phase lasts (div+1) clocks, where div is control bits [5:0] as sampled when the read starts.
- R8: A window write is ignored and acknowledged after one cycle without SCLK activity. A window read while function select bit 0 is set returns 0 after one cycle.
- R9: After a window read, chip select 0 returns high. When function select bit 0 is set again, the pins once more show the current I/O control contents.
- R10: In window mode with no read in progress, SCLK and MOSI are low and all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_win | input | 1 | 1 selects the flash window, 0 the registers |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 24 | Byte address (register offset in bits [3:0]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | One-cycle access completion pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 3 | Active-low chip selects |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest thing to reach from the ports is the alignment between the generated frame and the returned word. A one-edge slip in where data capture begins, or a wrong byte order, only shows up against a device that answers on the right edge. The bench therefore models a flash. It counts SCLK rising edges while chip select 0 is low, records MOSI on each edge, and from the fortieth edge on presents its data bits on the falling edges. It then compares the received word, the recorded command and address, and the measured high-phase length at two divider values. The shift-register rule is reached by software sequences that mix rising and non-rising SCLK writes in both modes, with MISO held at chosen values.

// File: rtl/spi_winctl_pkg.sv
package spi_winctl_pkg;
  localparam logic [3:0] OFF_FSEL = 4'h0;
  localparam logic [3:0] OFF_CTRL = 4'h4;
  localparam logic [3:0] OFF_IOC  = 4'h8;
  localparam logic [3:0] OFF_RDS  = 4'hC;

  localparam int IOC_MOSI_BIT = 0;
  localparam int IOC_SCLK_BIT = 8;
  localparam int IOC_CS_BASE  = 16;

  localparam logic [31:0] CTRL_RST   = 32'h0000_0043;
  localparam logic [7:0]  FAST_RD_OP = 8'h0B;

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI, F_END} fetch_st_t;
endpackage

// File: rtl/spi_winctl_regs.sv
module spi_winctl_regs
  import spi_winctl_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NCS  = 3,
  parameter int DIVW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    acc_off,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          miso,
  output logic          pin_mode,
  output logic [DIVW-1:0] clk_div,
  output logic [DW-1:0] ioc_q
);
  localparam logic [DW-1:0] IOC_RST = DW'(((64'd1 << NCS) - 64'd1) << IOC_CS_BASE);

  logic          fsel_q;
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] rds_q;
  logic          sclk_rise;

  assign sclk_rise = wr_en && (acc_off == OFF_IOC) && fsel_q &&
                     !ioc_q[IOC_SCLK_BIT] && wr_data[IOC_SCLK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_q <= 1'b0;
      ctrl_q <= DW'(CTRL_RST);
      ioc_q  <= IOC_RST;
      rds_q  <= '0;
    end else begin
      if (wr_en && acc_off == OFF_FSEL) fsel_q <= wr_data[0];
      if (wr_en && acc_off == OFF_CTRL) ctrl_q <= wr_data;
      if (wr_en && acc_off == OFF_IOC)  ioc_q  <= wr_data;
      if (sclk_rise) rds_q <= {rds_q[DW-2:0], miso};
    end
  end

  always_comb begin
    case (acc_off)
      OFF_FSEL: rd_data = DW'(fsel_q);
      OFF_CTRL: rd_data = ctrl_q;
      OFF_IOC:  rd_data = ioc_q;
      OFF_RDS:  rd_data = rds_q;
      default:  rd_data = '0;
    endcase
  end

  assign pin_mode = fsel_q;
  assign clk_div  = ctrl_q[DIVW-1:0];

  AST_RDS_RO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && acc_off == OFF_RDS) |=> $stable(rds_q)); // R4
endmodule

// File: rtl/spi_winctl_fetch.sv
module spi_winctl_fetch
  import spi_winctl_pkg::*;
#(
  parameter int AW   = 24,
  parameter int DW   = 32,
  parameter int DIVW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   addr,
  input  logic [DIVW-1:0] div,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic            sclk,
  output logic            mosi,
  output logic            cs_act,
  output logic [DW-1:0]   rx_data
);
  localparam int OPW    = $bits(FAST_RD_OP);
  localparam int DUMW   = 8;
  localparam int TOT    = OPW + AW + DUMW + DW;
  localparam int DSTART = TOT - DW;
  localparam int IW     = $clog2(TOT);

  fetch_st_t       st;
  logic [DIVW-1:0] cnt, div_q;
  logic [IW-1:0]   idx;
  logic [TOT-1:0]  tx;
  logic [DW-1:0]   rx;
  logic            sclk_q, cs_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= F_IDLE;
      cnt <= '0;
      div_q <= '0;
      idx <= '0;
      tx <= '0;
      rx <= '0;
      sclk_q <= 1'b0;
      cs_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        F_IDLE: if (start) begin
          tx     <= {FAST_RD_OP, addr, {DUMW{1'b0}}, {DW{1'b0}}};
          div_q  <= div;
          cnt    <= div;
          idx    <= '0;
          cs_q   <= 1'b1;
          sclk_q <= 1'b0;
          st     <= F_LO;
        end
        F_LO: if (cnt == '0) begin
          sclk_q <= 1'b1;
          if (idx >= IW'(DSTART)) rx <= {rx[DW-2:0], miso};
          cnt <= div_q;
          st  <= F_HI;
        end else begin
          cnt <= cnt - 1'b1;
        end
        F_HI: if (cnt == '0) begin
          sclk_q <= 1'b0;
          cnt    <= div_q;
          if (idx == IW'(TOT-1)) begin
            st <= F_END;
          end else begin
            idx <= idx + 1'b1;
            tx  <= {tx[TOT-2:0], 1'b0};
            st  <= F_LO;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        F_END: begin
          cs_q   <= 1'b0;
          done_q <= 1'b1;
          st     <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign busy    = (st != F_IDLE);
  assign done    = done_q;
  assign sclk    = sclk_q;
  assign mosi    = tx[TOT-1];
  assign cs_act  = cs_q;
  assign rx_data = rx;

  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == F_IDLE) |-> !sclk_q); // R10
  AST_BITS_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (idx == IW'(TOT-1))); // R6
endmodule

// File: rtl/spi_winctl_pinmux.sv
module spi_winctl_pinmux #(
  parameter int NCS = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pin_mode,
  input  logic           ioc_mosi,
  input  logic           ioc_sclk,
  input  logic [NCS-1:0] ioc_cs,
  input  logic           eng_sclk,
  input  logic           eng_mosi,
  input  logic           eng_cs_act,
  output logic           spi_sclk,
  output logic           spi_mosi,
  output logic [NCS-1:0] spi_cs_n
);
  logic [NCS-1:0] cs_nxt;

  for (genvar g = 0; g < NCS; g++) begin : g_lane
    if (g == 0) begin : g_flash
      assign cs_nxt[g] = pin_mode ? ioc_cs[g] : !eng_cs_act;
    end else begin : g_other
      assign cs_nxt[g] = pin_mode ? ioc_cs[g] : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spi_sclk <= 1'b0;
      spi_mosi <= 1'b0;
      spi_cs_n <= '1;
    end else begin
      spi_sclk <= pin_mode ? ioc_sclk : eng_sclk;
      spi_mosi <= pin_mode ? ioc_mosi : (eng_cs_act && eng_mosi);
      spi_cs_n <= cs_nxt;
    end
  end
endmodule

// File: rtl/spi_winctl.sv
module spi_winctl
  import spi_winctl_pkg::*;
#(
  parameter int AW   = 24,
  parameter int DW   = 32,
  parameter int NCS  = 3,
  parameter int DIVW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_req,
  input  logic           bus_win,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_ready,
  output logic           spi_sclk,
  output logic           spi_mosi,
  output logic [NCS-1:0] spi_cs_n,
  input  logic           spi_miso
);
  localparam int NB = DW / 8;

  logic            pin_mode, eng_busy, eng_done, eng_sclk, eng_mosi, eng_cs;
  logic [DIVW-1:0] clk_div;
  logic [DW-1:0]   ioc_q, reg_rdata, eng_rx, rx_swap;
  logic            pend, take, reg_wr, eng_start;

  assign take      = bus_req && !bus_ready && !pend;
  assign reg_wr    = take && !bus_win && bus_we;
  assign eng_start = take && bus_win && !bus_we && !pin_mode;

  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign rx_swap[8*b +: 8] = eng_rx[DW-8-8*b +: 8];
  end

  spi_winctl_regs #(.DW(DW), .NCS(NCS), .DIVW(DIVW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .acc_off(bus_addr[3:0]),
    .wr_data(bus_wdata), .rd_data(reg_rdata), .miso(spi_miso),
    .pin_mode(pin_mode), .clk_div(clk_div), .ioc_q(ioc_q)
  );

  spi_winctl_fetch #(.AW(AW), .DW(DW), .DIVW(DIVW)) u_fetch (
    .clk(clk), .rst(rst), .start(eng_start), .addr(bus_addr), .div(clk_div),
    .miso(spi_miso), .busy(eng_busy), .done(eng_done), .sclk(eng_sclk),
    .mosi(eng_mosi), .cs_act(eng_cs), .rx_data(eng_rx)
  );

  spi_winctl_pinmux #(.NCS(NCS)) u_pins (
    .clk(clk), .rst(rst), .pin_mode(pin_mode),
    .ioc_mosi(ioc_q[IOC_MOSI_BIT]), .ioc_sclk(ioc_q[IOC_SCLK_BIT]),
    .ioc_cs(ioc_q[IOC_CS_BASE +: NCS]),
    .eng_sclk(eng_sclk), .eng_mosi(eng_mosi), .eng_cs_act(eng_cs),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
      pend      <= 1'b0;
    end else begin
      bus_ready <= 1'b0;
      if (pend) begin
        if (eng_done) begin
          bus_ready <= 1'b1;
          bus_rdata <= rx_swap;
          pend      <= 1'b0;
        end
      end else if (take) begin
        if (!bus_win) begin
          bus_ready <= 1'b1;
          bus_rdata <= reg_rdata;
        end else if (bus_we || pin_mode) begin
          bus_ready <= 1'b1;
          bus_rdata <= '0;
        end else begin
          pend <= 1'b1;
        end
      end
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready); // R2
  AST_WIN_CS0_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(eng_busy && !pin_mode) |-> !spi_cs_n[0]); // R5
  AST_WIN_IDLE_CS: assert property (@(posedge clk) disable iff (rst)
    $past(!eng_busy && !pin_mode) |-> (&spi_cs_n)); // R9
  AST_WIN_IDLE_SCLK: assert property (@(posedge clk) disable iff (rst)
    $past(!eng_busy && !pin_mode) |-> (!spi_sclk && !spi_mosi)); // R10
endmodule

// File: tb/sim_spi_winctl.sv
module sim_spi_winctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_win = 1'b0, bus_we = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [2:0]  spi_cs_n;

  always #4 clk = ~clk;

  spi_winctl u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_win(bus_win), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
  );

  int n_chk = 0, n_bad = 0;

  // flash model
  logic        slv_en = 1'b0, slv_miso = 1'b0, pin_miso = 1'b0;
  logic [31:0] slv_data = '0;
  logic [71:0] slv_rx = '0;
  int          slv_cnt = 0, slv_cs_bad = 0;
  assign spi_miso = slv_en ? slv_miso : pin_miso;

  always @(negedge spi_cs_n[0]) if (slv_en) begin
    slv_cnt = 0; slv_rx = '0; slv_cs_bad = 0; slv_miso = 1'b0;
  end
  always @(posedge spi_sclk) if (slv_en) begin
    slv_rx = {slv_rx[70:0], spi_mosi};
    slv_cnt++;
    if (spi_cs_n !== 3'b110) slv_cs_bad++;
  end
  always @(negedge spi_sclk) if (slv_en && slv_cnt >= 40 && slv_cnt < 72)
    slv_miso = slv_data[31-(slv_cnt-40)];

  // software-side model
  logic        pm = 1'b0;
  logic [31:0] cur_ioc = 32'h0007_0000;
  logic [31:0] exp_rds = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic we, input logic [23:0] a,
                     input logic [31:0] d, output logic [31:0] r, output int lat);
    @(negedge clk);
    bus_req = 1'b1; bus_win = w; bus_we = we; bus_addr = a; bus_wdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!bus_ready && lat < 20000);
    r = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] off, input logic [31:0] v);
    logic [31:0] r; int lat;
    bus(1'b0, 1'b1, {20'h0, off}, v, r, lat);
    if (off == 4'h8) begin
      if (pm && !cur_ioc[8] && v[8]) exp_rds = {exp_rds[30:0], pin_miso};
      cur_ioc = v;
    end
    if (off == 4'h0) pm = v[0];
  endtask

  task automatic rd(input logic [3:0] off, output logic [31:0] r, output int lat);
    bus(1'b0, 1'b0, {20'h0, off}, 32'h0, r, lat);
  endtask

  task automatic measure(output int n);
    @(posedge spi_sclk);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (spi_sclk && n < 1000);
  endtask

  task automatic chk_pins(input string tag, input logic m, input logic s, input logic [2:0] c);
    chk({tag, " mosi"}, {31'h0, spi_mosi}, {31'h0, m});
    chk({tag, " sclk"}, {31'h0, spi_sclk}, {31'h0, s});
    chk({tag, " cs_n"}, {29'h0, spi_cs_n}, {29'h0, c});
  endtask

  task automatic t_reset();
    logic [31:0] r; int lat;
    chk_pins("R1 reset pins", 1'b0, 1'b0, 3'b111);
    rd(4'h0, r, lat); chk("R1 fsel", r, 32'h0);
    chk("R2 read latency", lat, 1);
    rd(4'h4, r, lat); chk("R1 ctrl", r, 32'h43);
    rd(4'h8, r, lat); chk("R1 ioc", r, 32'h0007_0000);
    rd(4'hC, r, lat); chk("R1 rds", r, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] r; int lat;
    wr(4'h4, 32'h0000_0001);
    rd(4'h4, r, lat); chk("R2 ctrl readback", r, 32'h1);
    wr(4'h8, 32'h0006_0100);
    rd(4'h8, r, lat); chk("R2 ioc readback", r, 32'h0006_0100);
    chk_pins("R10 window idle pins", 1'b0, 1'b0, 3'b111);
    rd(4'hC, r, lat); chk("R4 no shift in window mode", r, exp_rds);
  endtask

  task automatic t_winrd(input logic [23:0] a, input logic [31:0] d, input int half);
    logic [31:0] r; int lat, h;
    slv_en = 1'b1; slv_data = d;
    fork
      bus(1'b1, 1'b0, a, 32'h0, r, lat);
      measure(h);
    join
    chk("R6 rdata byte order", r, {d[7:0], d[15:8], d[23:16], d[31:24]});
    chk("R5 rising edges", slv_cnt, 72);
    chk("R5 command/address", slv_rx[71:40], {8'h0B, a});
    chk("R5 dummy byte", {24'h0, slv_rx[39:32]}, 32'h0);
    chk("R5 cs during frame", slv_cs_bad, 0);
    chk("R7 sclk high phase", h, half);
    chk("R6 ready held low", {31'h0, (lat >= 144 * half)}, 32'h1);
    chk_pins("R9 after window read", 1'b0, 1'b0, 3'b111);
    slv_en = 1'b0;
  endtask

  task automatic t_winwr();
    logic [31:0] r; int lat, c0;
    slv_en = 1'b1; c0 = slv_cnt;
    bus(1'b1, 1'b1, 24'h00_0040, 32'hDEAD_BEEF, r, lat);
    chk("R8 window write latency", lat, 1);
    repeat (20) @(negedge clk);
    chk("R8 window write no sclk", slv_cnt, c0);
    chk_pins("R8 window write pins", 1'b0, 1'b0, 3'b111);
    slv_en = 1'b0;
  endtask

  task automatic t_pins();
    logic [31:0] r; int lat;
    wr(4'h0, 32'h1);
    chk_pins("R9 pins restored to ioc", 1'b0, 1'b1, 3'b110);
    pin_miso = 1'b1;
    wr(4'h8, 32'h0005_0001);
    chk_pins("R3 ioc 0x00050001", 1'b1, 1'b0, 3'b101);
    wr(4'h8, 32'h0003_0101);
    chk_pins("R3 ioc 0x00030101", 1'b1, 1'b1, 3'b011);
    pin_miso = 1'b0;
    wr(4'h8, 32'h0007_0000);
    wr(4'h8, 32'h0007_0100);
    pin_miso = 1'b1;
    wr(4'h8, 32'h0007_0100);
    wr(4'h8, 32'h0007_0000);
    wr(4'h8, 32'h0007_0100);
    rd(4'hC, r, lat);
    chk("R4 rds model", r, exp_rds);
    chk("R4 rds value", r, 32'h5);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, r, lat);
    chk("R4 rds write ignored", r, 32'h5);
  endtask

  task automatic t_winrd_pinmode();
    logic [31:0] r; int lat;
    bus(1'b1, 1'b0, 24'h00_1000, 32'h0, r, lat);
    chk("R8 pin-mode window read latency", lat, 1);
    chk("R8 pin-mode window read data", r, 32'h0);
    chk_pins("R8 pins keep ioc", 1'b0, 1'b1, 3'b111);
    wr(4'h0, 32'h0);
    rd(4'h0, r, lat); chk("R2 fsel readback", r, 32'h0);
    chk_pins("R10 back to window idle", 1'b0, 1'b0, 3'b111);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_winrd(24'h12_3456, 32'hA1B2_C3D4, 2);
    wr(4'h4, 32'h0000_0043);
    t_winrd(24'hFE_DCBA, 32'h0F1E_2D3C, 4);
    t_winwr();
    t_pins();
    t_winrd_pinmode();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule